// File: doc/BRIEF.md
# GPIO Port Input Debounce Filter

This block cleans up the eight already-synchronized input pins of one GPIO port. All pins of the port share one 8-bit debounce length, counted in millisecond ticks. Each pin also has its own enable. When a pin is enabled, a new level reaches the filtered output only after the raw pin has held that level through the programmed number of 1 ms tick strobes. When a pin is disabled, or the shared length is zero, the pin is registered once and passed straight through.

The filtered vector feeds the port's input register and its interrupt detector. Configuration arrives over a simple write strobe. The block takes its tick strobe from outside and does not derive it from the clock.

The per-pin enables are written through a masked alias. One write can therefore change any subset of the pins without a read-modify-write. Every pin keeps its own stability counter, and the shared length is compared against that counter on each tick.

Top module: `port_debounce_filter`

## Requirements
- R1: While rst_ni is low, pin_filt_o is 0, all pin enables are 0 and the shared length is 0.
- R2: A write with wr_sel_i = 0 loads wr_data_i[7:0] as the shared length, and the new value is used from the next cycle onward. The length is held whenever no write occurs.
- R3: A write with wr_sel_i = 1 treats wr_data_i[15:8] as a per-pin mask and wr_data_i[7:0] as per-pin values: bit i of the data sets the enable of pin i only where mask bit 8+i is 1. Pins whose mask bit is 0 keep their enable.
- R4: A disabled pin shows its raw input on pin_filt_o one clock later.
- R5: While the shared length is 0, every pin follows its raw input one clock later, whatever its enable.
- R6: For an enabled pin with length N ≥ 1, the output takes the raw level at the clock edge of the Nth tick counted while the raw level has continuously differed from the output. The output never changes in a cycle without a tick.
- R7: If the raw level of an enabled pin returns to the output level before the Nth tick, the pin's progress is discarded, and a later change must count N fresh ticks.
- R8: Writing a new length keeps each pin's progress and does not change any output. On the next tick the new length is compared, so a pin whose progress already reaches the new length switches on that tick. A tick in the same cycle as the write is compared against the old length.
- R9: Each pin keeps its own progress: activity on one pin does not delay or advance another pin.
- R10: Disabling a pin part-way through filtering discards its progress, and its output follows the raw level from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_sync_i | input | 8 | Synchronized raw pin levels |
| ms_tick_i | input | 1 | One-cycle strobe every millisecond |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_sel_i | input | 1 | 0: shared length, 1: masked enable alias |
| wr_data_i | input | 16 | Write data |
| pin_filt_o | output | 8 | Filtered pin levels |

## Verification
A tick and a configuration write can fall in the same clock. In that clock the filter decision must use the length and enables as they stood before the write. The directed case provokes this by building a pin's progress to one tick short of the old length, then raising the length in the same cycle as a tick. The pin is judged correct only if it switches on that very tick. The random phase overlaps writes, ticks and pin changes freely, and every cycle is compared against a bench model that updates its configuration only after it has evaluated the filters.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
  typedef enum logic {
    SEL_LENGTH = 1'b0,
    SEL_ENABLE = 1'b1
  } dbc_sel_e;
endpackage

// File: rtl/dbc_cfg_regs.sv
module dbc_cfg_regs
  import dbc_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int CNT_W  = 8,
  localparam int DATA_W = 2 * NPINS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [NPINS-1:0]  en_o,
  output logic [CNT_W-1:0]  len_o
);
  dbc_sel_e sel;
  assign sel = dbc_sel_e'(wr_sel_i);

  // R2: shared length
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) len_o <= '0;
    else if (wr_en_i && sel == SEL_LENGTH) len_o <= wr_data_i[CNT_W-1:0];
  end

  // R3: masked alias, one bit per pin
  for (genvar i = 0; i < NPINS; i++) begin : g_en
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_o[i] <= 1'b0;
      else if (wr_en_i && sel == SEL_ENABLE && wr_data_i[NPINS+i])
        en_o[i] <= wr_data_i[i];
    end
  end
endmodule

// File: rtl/dbc_pin_filter.sv
module dbc_pin_filter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raw_i,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             filt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] stab_q;
  logic             bypass;

  assign bypass = !en_i || (len_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_o <= 1'b0;
      stab_q <= '0;
    end else if (bypass) begin
      // R4 R5 R10
      filt_o <= raw_i;
      stab_q <= '0;
    end else if (raw_i == filt_o) begin
      // R7
      stab_q <= '0;
    end else if (tick_i) begin
      // R6 R8: >= so a lowered length releases on the next tick
      if (stab_q >= len_i - ONE) begin
        filt_o <= raw_i;
        stab_q <= '0;
      end else begin
        stab_q <= stab_q + ONE;
      end
    end
  end
endmodule

// File: rtl/port_debounce_filter.sv
module port_debounce_filter #(
  parameter int NPINS  = 8,
  parameter int CNT_W  = 8,
  localparam int DATA_W = 2 * NPINS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPINS-1:0]  pin_sync_i,
  input  logic              ms_tick_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [NPINS-1:0]  pin_filt_o
);
  logic [NPINS-1:0] en_q;
  logic [CNT_W-1:0] len_q;

  dbc_cfg_regs #(.NPINS(NPINS), .CNT_W(CNT_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .en_o      (en_q),
    .len_o     (len_q)
  );

  // R9: independent counter per pin
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    dbc_pin_filter #(.CNT_W(CNT_W)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (pin_sync_i[i]),
      .en_i   (en_q[i]),
      .tick_i (ms_tick_i),
      .len_i  (len_q),
      .filt_o (pin_filt_o[i])
    );
  end
endmodule

// File: rtl/port_debounce_filter_chk.sv
module port_debounce_filter_chk #(
  parameter int NPINS  = 8,
  parameter int CNT_W  = 8,
  localparam int DATA_W = 2 * NPINS
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NPINS-1:0]  pin_sync_i,
  input logic              ms_tick_i,
  input logic              wr_en_i,
  input logic              wr_sel_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [NPINS-1:0]  pin_filt_o,
  input logic [NPINS-1:0]  en_q,
  input logic [CNT_W-1:0]  len_q
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_state_chk: assert (pin_filt_o == '0 && en_q == '0 && len_q == '0);
    end
  end

  // R2
  len_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i) |=> (len_q == $past(wr_data_i[CNT_W-1:0])));

  // R2
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(en_q) && $stable(len_q)));

  // R5
  zero_len_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_q == '0) |=> (pin_filt_o == $past(pin_sync_i)));

  for (genvar i = 0; i < NPINS; i++) begin : g_pin_chk
    // R3
    mask_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_sel_i && !wr_data_i[NPINS+i]) |=> $stable(en_q[i]));

    // R4
    disabled_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_q[i] |=> (pin_filt_o[i] == $past(pin_sync_i[i])));

    // R6
    no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_q[i] && len_q != '0 && !ms_tick_i) |=> $stable(pin_filt_o[i]));

    // R7
    agree_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_q[i] && len_q != '0 && pin_sync_i[i] == pin_filt_o[i]) |=> $stable(pin_filt_o[i]));
  end
endmodule

bind port_debounce_filter port_debounce_filter_chk #(.NPINS(NPINS), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pin_sync_i (pin_sync_i),
  .ms_tick_i  (ms_tick_i),
  .wr_en_i    (wr_en_i),
  .wr_sel_i   (wr_sel_i),
  .wr_data_i  (wr_data_i),
  .pin_filt_o (pin_filt_o),
  .en_q       (en_q),
  .len_q      (len_q)
);

// File: tb/port_debounce_filter_bench.sv
module port_debounce_filter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NPINS = 8;
  localparam int CNT_W = 8;
  localparam int WATCHDOG = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  raw = '0;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic        sel = 1'b0;
  logic [15:0] wdata = '0;
  logic [7:0]  filt;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  // bench model
  logic [7:0] m_en, m_filt;
  logic [7:0] m_len;
  int         m_stab [NPINS];

  always #(CLK_PERIOD/2) clk = ~clk;

  port_debounce_filter #(.NPINS(NPINS), .CNT_W(CNT_W)) u_port_debounce_filter (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pin_sync_i (raw),
    .ms_tick_i  (tick),
    .wr_en_i    (we),
    .wr_sel_i   (sel),
    .wr_data_i  (wdata),
    .pin_filt_o (filt)
  );

  function automatic string mode_tag(input int i);
    if (m_len == 0) return "R5";
    if (!m_en[i]) return "R4";
    return "R6";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = '0; m_filt = '0; m_len = '0;
      for (int i = 0; i < NPINS; i++) m_stab[i] = 0;
    end else begin
      for (int i = 0; i < NPINS; i++) begin
        if (!m_en[i] || m_len == 0) begin
          m_filt[i] = raw[i]; m_stab[i] = 0;
        end else if (raw[i] == m_filt[i]) begin
          m_stab[i] = 0;
        end else if (tick) begin
          m_stab[i]++;
          if (m_stab[i] >= int'(m_len)) begin
            m_filt[i] = raw[i]; m_stab[i] = 0;
          end
        end
      end
      if (we && !sel) m_len = wdata[7:0];
      if (we && sel) m_en = (m_en & ~wdata[15:8]) | (wdata[7:0] & wdata[15:8]);
    end
  end

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < NPINS; i++) begin
        checks++;
        if (filt[i] !== m_filt[i]) begin
          fails++;
          $display("FAIL %s pin %0d: actual %b expected %b at %0t", mode_tag(i), i, filt[i], m_filt[i], $time);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic cyc(input logic t, input logic w = 1'b0, input logic s = 1'b0, input logic [15:0] d = '0);
    @(negedge clk);
    tick = t; we = w; sel = s; wdata = d;
    @(posedge clk);
    #1;
    tick = 1'b0; we = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    // R1
    check(filt, 8'h00, "R1");
    raw = 8'hff;
    @(posedge clk); #1;
    check(filt, 8'h00, "R1");
    raw = 8'h00;
    @(negedge clk);
    rst_n = 1'b1;

    cyc(0, 1, 0, 16'h0003);          // R2: length 3
    cyc(0, 1, 1, 16'hffff);          // R3: enable all
    raw = 8'h01;
    cyc(1); cyc(1);
    check(filt, 8'h00, "R6 before Nth tick");
    cyc(0); cyc(0);
    check(filt, 8'h00, "R6 no tick no change");
    cyc(1);
    check(filt, 8'h01, "R6 Nth tick");

    // R7 glitch back discards progress
    raw = 8'h00;
    cyc(1); cyc(1);
    raw = 8'h01; cyc(0);
    raw = 8'h00;
    cyc(1); cyc(1);
    check(filt, 8'h01, "R7 restart");
    cyc(1);
    check(filt, 8'h00, "R7 release");

    // R8 lowering length keeps progress
    raw = 8'h02;
    cyc(1); cyc(1);
    cyc(0, 1, 0, 16'h0001);
    check(filt, 8'h00, "R8 write no output change");
    cyc(1);
    check(filt, 8'h02, "R8 release on next tick");

    // R8 write and tick in same cycle: old length applies
    cyc(0, 1, 0, 16'h0003);
    raw = 8'h06;
    cyc(1); cyc(1);
    check(filt, 8'h02, "R9 pin1 unaffected, pin2 pending");
    cyc(1, 1, 0, 16'h0005);
    check(filt, 8'h06, "R8 same-cycle tick uses old length");

    // R3 masked alias disables pin0 only; R9 others keep filtering
    cyc(0, 1, 1, 16'h0100);
    raw = 8'h09;
    cyc(0);
    check(filt, 8'h07, "R3 R4 pin0 bypass");

    // R5 zero length bypasses all
    cyc(0, 1, 0, 16'h0000);
    cyc(0);
    check(filt, 8'h09, "R5 zero length");

    // R10 disable mid-filter
    cyc(0, 1, 0, 16'h0004);
    cyc(0, 1, 1, 16'hffff);
    raw = 8'h30;
    cyc(1); cyc(1);
    check(filt, 8'h09, "R10 pending");
    cyc(0, 1, 1, 16'h1000);
    cyc(0);
    check(filt, 8'h19, "R10 pin4 follows raw");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] flip;
      flip = '0;
      for (int b = 0; b < NPINS; b++) if ($urandom_range(15) == 0) flip[b] = 1'b1;
      raw = raw ^ flip;
      if ($urandom_range(19) == 0) begin
        if ($urandom_range(1) == 0)
          cyc($urandom_range(2) == 0, 1, 0, {8'h00, 8'($urandom_range(5))});
        else
          cyc($urandom_range(2) == 0, 1, 1, 16'($urandom()));
      end else begin
        cyc($urandom_range(2) == 0);
      end
    end

    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule